// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the pair of command words that a local interrupt controller exposes to software for sending an interrupt to other processors. The high word holds the target identifier. The low word holds the vector, the delivery mode, the destination mode, the level, the trigger mode and a two-bit destination shorthand. Writing the low word is the command that starts a send.

When a low-word write is accepted, the block stores the new fields and raises a delivery-status flag. From the stored fields it builds one outbound message and holds it on a valid/ready port until the fabric takes it. The flag reads back in bit 12 of the low word and clears when the message handshake completes. While the flag is set, any further low-word write is dropped without effect. The shorthand field becomes a two-bit routing code on the message port. Only code 0 uses the destination taken from the high word.

Top module: `ipi_cmd`

## Requirements
- R1: After reset both words read as zero and `msg_valid` is low.
- R2: The low word reads back vector in bits 7:0, delivery mode in 10:8, destination mode in 11, level in 14, trigger in 15, shorthand in 19:18 and the busy flag in bit 12. All other bits read 0. Bit 12 cannot be written.
- R3: The high word stores and reads back the destination in bits 31:24, and all its other bits read 0. High-word writes are accepted even while busy.
- R4: A low-word write made while busy is dropped. The low word keeps its contents and no new message starts.
- R5: An accepted low-word write updates the low word. From the next cycle, bit 12 reads 1 and `msg_valid` is high.
- R6: The message carries the vector, delivery mode, destination mode, level and trigger from the accepted low-word write.
- R7: For shorthand 0, `msg_route` is 0 and `msg_dest` equals the high-word destination at the moment the low word is written.
- R8: For shorthand 1 (self), 2 (all including self) and 3 (all excluding self), `msg_route` equals the shorthand value and `msg_dest` is driven to 0.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and every message field stays stable.
- R10: In the cycle after `msg_valid` and `msg_ready` are both high, `msg_valid` is low and bit 12 reads 0. A following low-word write is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_sel_hi | input | 1 | Word select: 1 selects the high word, 0 the low word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_route | output | 2 | Routing code: 0 directed, 1 self, 2 all with self, 3 all but self |
| msg_dest | output | 8 | Destination identifier (0 unless route is 0) |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_dst_logical | output | 1 | Destination mode |
| msg_level | output | 1 | Level bit |
| msg_trigger | output | 1 | Trigger mode bit |

## Verification
The assertions check on every cycle that a busy low-word write leaves the stored low word untouched, and that an accepted write is followed by busy. They also check that a pending message holds steady until ready, that a handshake drops valid, and that shorthand routes never carry a destination. Only the bench scenarios can show that the right bits are decoded from the bus and that unused bits read zero. The same holds for capture of the high-word destination at trigger time, for a high-word write during busy leaving the pending message unchanged, and for a new send being accepted once the handshake is done.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
   // Field positions of the low command word (software-visible layout)
   localparam int LO_VEC_LSB   = 0;
   localparam int LO_DMODE_LSB = 8;
   localparam int LO_DSTM_BIT  = 11;
   localparam int LO_BUSY_BIT  = 12;
   localparam int LO_LEVEL_BIT = 14;
   localparam int LO_TRIG_BIT  = 15;
   localparam int LO_SH_LSB    = 18;
   // Field position of the high command word
   localparam int HI_DEST_LSB  = 24;

   typedef enum logic [1:0] {
      ROUTE_DIRECT   = 2'd0,
      ROUTE_SELF     = 2'd1,
      ROUTE_ALL_INCL = 2'd2,
      ROUTE_ALL_EXCL = 2'd3
   } route_e;
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
   import ipi_cmd_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int VEC_W   = 8,
   parameter int DMODE_W = 3,
   parameter int DEST_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               sel_hi,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               busy,
   output logic               accept_lo,
   output logic [DEST_W-1:0]  hi_dest,
   output logic [DATA_W-1:0]  rdata
);
   localparam int SH_W = 2;

   initial begin : p_param_chk
      assert (DATA_W == 32) else $error("ipi_cmd_regs: DATA_W must be 32");
      assert (LO_VEC_LSB + VEC_W <= LO_DMODE_LSB) else $error("ipi_cmd_regs: VEC_W overlaps delivery mode");
      assert (LO_DMODE_LSB + DMODE_W <= LO_DSTM_BIT) else $error("ipi_cmd_regs: DMODE_W overlaps destination mode");
      assert (HI_DEST_LSB + DEST_W <= DATA_W) else $error("ipi_cmd_regs: DEST_W too wide");
   end

   logic [VEC_W-1:0]   vec_q;
   logic [DMODE_W-1:0] dmode_q;
   logic               dstm_q, level_q, trig_q;
   logic [SH_W-1:0]    sh_q;

   assign accept_lo = wr_en && !sel_hi && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q   <= '0;
         dmode_q <= '0;
         dstm_q  <= 1'b0;
         level_q <= 1'b0;
         trig_q  <= 1'b0;
         sh_q    <= '0;
      end else if (accept_lo) begin
         vec_q   <= wdata[LO_VEC_LSB +: VEC_W];
         dmode_q <= wdata[LO_DMODE_LSB +: DMODE_W];
         dstm_q  <= wdata[LO_DSTM_BIT];
         level_q <= wdata[LO_LEVEL_BIT];
         trig_q  <= wdata[LO_TRIG_BIT];
         sh_q    <= wdata[LO_SH_LSB +: SH_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_dest <= '0;
      else if (wr_en && sel_hi)
         hi_dest <= wdata[HI_DEST_LSB +: DEST_W];
   end

   logic [DATA_W-1:0] lo_word, hi_word;

   always_comb begin
      lo_word = '0;
      lo_word[LO_VEC_LSB +: VEC_W]     = vec_q;
      lo_word[LO_DMODE_LSB +: DMODE_W] = dmode_q;
      lo_word[LO_DSTM_BIT]             = dstm_q;
      lo_word[LO_BUSY_BIT]             = busy;
      lo_word[LO_LEVEL_BIT]            = level_q;
      lo_word[LO_TRIG_BIT]             = trig_q;
      lo_word[LO_SH_LSB +: SH_W]       = sh_q;
      hi_word = '0;
      hi_word[HI_DEST_LSB +: DEST_W]   = hi_dest;
   end

   assign rdata = sel_hi ? hi_word : lo_word;

   // R4: a low-word write while busy leaves every stored low field untouched
   a_r4_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel_hi && busy) |=> ($stable(vec_q) && $stable(dmode_q) && $stable(dstm_q)
                                      && $stable(level_q) && $stable(trig_q) && $stable(sh_q)));
endmodule

// File: rtl/ipi_cmd_launch.sv
module ipi_cmd_launch
   import ipi_cmd_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int DMODE_W    = 3,
   parameter int DEST_W     = 8,
   parameter bit CLEAR_DEST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [VEC_W-1:0]   new_vec,
   input  logic [DMODE_W-1:0] new_dmode,
   input  logic               new_dstm,
   input  logic               new_level,
   input  logic               new_trig,
   input  logic [1:0]         new_sh,
   input  logic [DEST_W-1:0]  cur_dest,
   input  logic               msg_ready,
   output logic               busy,
   output logic               msg_valid,
   output logic [1:0]         msg_route,
   output logic [DEST_W-1:0]  msg_dest,
   output logic [VEC_W-1:0]   msg_vector,
   output logic [DMODE_W-1:0] msg_dmode,
   output logic               msg_dst_logical,
   output logic               msg_level,
   output logic               msg_trigger
);
   initial begin : p_param_chk
      assert (VEC_W > 0 && DMODE_W > 0 && DEST_W > 0) else $error("ipi_cmd_launch: widths must be positive");
   end

   logic [DEST_W-1:0] dest_sel;
   logic              handshake;

   // Destination routed onto the message: variant picked by parameter
   generate
      if (CLEAR_DEST) begin : g_clear_dest
         assign dest_sel = (route_e'(new_sh) == ROUTE_DIRECT) ? cur_dest : '0;
      end else begin : g_pass_dest
         assign dest_sel = cur_dest;
      end
   endgenerate

   assign handshake = msg_valid && msg_ready;
   assign busy      = msg_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         msg_valid <= 1'b0;
      else if (accept)
         msg_valid <= 1'b1;
      else if (handshake)
         msg_valid <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_route       <= '0;
         msg_dest        <= '0;
         msg_vector      <= '0;
         msg_dmode       <= '0;
         msg_dst_logical <= 1'b0;
         msg_level       <= 1'b0;
         msg_trigger     <= 1'b0;
      end else if (accept) begin
         msg_route       <= new_sh;
         msg_dest        <= dest_sel;
         msg_vector      <= new_vec;
         msg_dmode       <= new_dmode;
         msg_dst_logical <= new_dstm;
         msg_level       <= new_level;
         msg_trigger     <= new_trig;
      end
   end

   // R5: an accepted write is followed by busy
   a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);

   // R9: a pending message stays valid and unchanged until taken
   a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_route) && $stable(msg_dest)
                                     && $stable(msg_vector) && $stable(msg_dmode)
                                     && $stable(msg_dst_logical) && $stable(msg_level)
                                     && $stable(msg_trigger)));

   // R10: a completed handshake drops valid in the next cycle
   a_r10_clear_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      handshake |=> !msg_valid);

   // R8: shorthand routes never carry a destination
   a_r8_shorthand_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_route != 2'd0 && CLEAR_DEST) |-> (msg_dest == '0));
endmodule

// File: rtl/ipi_cmd.sv
module ipi_cmd
   import ipi_cmd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int VEC_W      = 8,
   parameter int DMODE_W    = 3,
   parameter int DEST_W     = 8,
   parameter bit CLEAR_DEST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_sel_hi,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [1:0]         msg_route,
   output logic [DEST_W-1:0]  msg_dest,
   output logic [VEC_W-1:0]   msg_vector,
   output logic [DMODE_W-1:0] msg_dmode,
   output logic               msg_dst_logical,
   output logic               msg_level,
   output logic               msg_trigger
);
   logic              busy, accept_lo;
   logic [DEST_W-1:0] hi_dest;

   ipi_cmd_regs #(
      .DATA_W (DATA_W), .VEC_W (VEC_W), .DMODE_W (DMODE_W), .DEST_W (DEST_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .sel_hi    (bus_sel_hi),
      .wdata     (bus_wdata),
      .busy      (busy),
      .accept_lo (accept_lo),
      .hi_dest   (hi_dest),
      .rdata     (bus_rdata)
   );

   ipi_cmd_launch #(
      .VEC_W (VEC_W), .DMODE_W (DMODE_W), .DEST_W (DEST_W), .CLEAR_DEST (CLEAR_DEST)
   ) i_launch (
      .clk             (clk),
      .rst_n           (rst_n),
      .accept          (accept_lo),
      .new_vec         (bus_wdata[LO_VEC_LSB +: VEC_W]),
      .new_dmode       (bus_wdata[LO_DMODE_LSB +: DMODE_W]),
      .new_dstm        (bus_wdata[LO_DSTM_BIT]),
      .new_level       (bus_wdata[LO_LEVEL_BIT]),
      .new_trig        (bus_wdata[LO_TRIG_BIT]),
      .new_sh          (bus_wdata[LO_SH_LSB +: 2]),
      .cur_dest        (hi_dest),
      .msg_ready       (msg_ready),
      .busy            (busy),
      .msg_valid       (msg_valid),
      .msg_route       (msg_route),
      .msg_dest        (msg_dest),
      .msg_vector      (msg_vector),
      .msg_dmode       (msg_dmode),
      .msg_dst_logical (msg_dst_logical),
      .msg_level       (msg_level),
      .msg_trigger     (msg_trigger)
   );

   // R1: nothing is pending while in reset
   a_r1_idle_in_reset: assert property (@(posedge clk) !rst_n |-> !msg_valid);
endmodule

// File: tb/test_ipi_cmd.sv
`timescale 1ns/1ps
module test_ipi_cmd;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_sel_hi = 1'b0, msg_ready = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_valid, msg_dst_logical, msg_level, msg_trigger;
   logic [1:0]  msg_route;
   logic [7:0]  msg_dest, msg_vector;
   logic [2:0]  msg_dmode;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   ipi_cmd i_ipi_cmd (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_hi(bus_sel_hi),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_route(msg_route), .msg_dest(msg_dest),
      .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_dst_logical(msg_dst_logical),
      .msg_level(msg_level), .msg_trigger(msg_trigger)
   );

   localparam logic [31:0] LO_MASK = 32'h000C_CFFF;
   localparam logic [31:0] HI_MASK = 32'hFF00_0000;

   // {hi word, lo word, expected route, expected dest}
   typedef struct packed {
      logic [31:0] hi;
      logic [31:0] lo;
      logic [1:0]  route;
      logic [7:0]  dest;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{32'h1200_0000, 32'h0000_0031, 2'd0, 8'h12},
      '{32'hA5FF_FFFF, 32'hFFF3_FFFF, 2'd0, 8'hA5},
      '{32'h7E00_0000, 32'h0004_0840, 2'd1, 8'h00},
      '{32'h3C00_0000, 32'h0008_4520, 2'd2, 8'h00},
      '{32'h0100_0000, 32'h000C_8302, 2'd3, 8'h00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic hi, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel_hi = hi; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic hi, output logic [31:0] d);
      bus_sel_hi = hi;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic take();
      @(negedge clk);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      #(4 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : main
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 valid", {31'b0, msg_valid}, 32'h0);
      rd(1'b0, r); check("R1 low word", r, 32'h0);
      rd(1'b1, r); check("R1 high word", r, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 5; i++) begin
         vec_t v = VECS[i];
         wr(1'b1, v.hi);
         rd(1'b1, r); check("R3 high readback", r, v.hi & HI_MASK);
         wr(1'b0, v.lo);
         check("R5 valid after write", {31'b0, msg_valid}, 32'h1);
         check("R7/R8 route", {30'b0, msg_route}, {30'b0, v.route});
         check(v.route == 2'd0 ? "R7 dest" : "R8 dest", {24'b0, msg_dest}, {24'b0, v.dest});
         check("R6 vector", {24'b0, msg_vector}, {24'b0, v.lo[7:0]});
         check("R6 delivery mode", {29'b0, msg_dmode}, {29'b0, v.lo[10:8]});
         check("R6 fields dstm/level/trig", {29'b0, msg_dst_logical, msg_level, msg_trigger},
               {29'b0, v.lo[11], v.lo[14], v.lo[15]});
         rd(1'b0, r); check("R2 low readback busy", r, (v.lo & LO_MASK) | 32'h0000_1000);
         repeat (2) @(negedge clk);
         check("R9 held valid", {31'b0, msg_valid}, 32'h1);
         check("R9 held vector", {24'b0, msg_vector}, {24'b0, v.lo[7:0]});
         take();
         check("R10 valid cleared", {31'b0, msg_valid}, 32'h0);
         rd(1'b0, r); check("R10 busy cleared", r, v.lo & LO_MASK);
      end

      // R4: write while busy is dropped; R3: high write during busy accepted
      wr(1'b1, 32'h5500_0000);
      wr(1'b0, 32'h0000_0377);
      wr(1'b0, 32'h000C_C0AA);
      rd(1'b0, r); check("R4 low word kept", r, 32'h0000_1377);
      check("R4 message unchanged", {24'b0, msg_vector}, 32'h77);
      check("R4 route unchanged", {30'b0, msg_route}, 32'h0);
      wr(1'b1, 32'h6600_0000);
      rd(1'b1, r); check("R3 high write while busy", r, 32'h6600_0000);
      check("R7 dest captured at trigger", {24'b0, msg_dest}, 32'h55);
      take();
      check("R4 single message", {31'b0, msg_valid}, 32'h0);
      @(negedge clk);
      check("R4 no second message", {31'b0, msg_valid}, 32'h0);
      // R2: bit 12 not writable; R10: new write accepted after handshake
      wr(1'b0, 32'h0004_1099);
      check("R10 accepted after clear", {31'b0, msg_valid}, 32'h1);
      check("R8 self route", {30'b0, msg_route}, 32'h1);
      check("R8 self dest zero", {24'b0, msg_dest}, 32'h0);
      take();
      rd(1'b0, r); check("R2 bit12 not writable", r, 32'h0004_0099);
      summary();
   end
endmodule